// File: doc/BRIEF.md
# Walking-Bit Address Uniqueness Tester

This self-test engine looks for addressing faults in a memory that is one bit wide. Such a memory cannot hold a different value at each address, so the engine uses a single flipped bit instead. It first writes a uniform background value, all zeros or all ones, to every location. It then takes each address in turn as the target. For each target it writes the inverted value to that one location and reads the whole array back. Every read is compared with its expected value: the inverted value at the target, and the background value everywhere else. Before the next target is flipped, the target location is written back to the background value.

The engine drives a synchronous single-bit memory port whose read data arrives one cycle after the read request. Reads are pipelined, so one address is compared on every clock. The engine stops at the first mismatch. It then holds the target address, the read address and the bit value exactly as it was seen when the mismatch was found; memory is not read again. If no mismatch is found, it raises `done` with `fail` low. A new `start` pulse begins another run. Refresh, strobe timing and retention delays are outside this block.

Top module: `walkbit_tester`

## Requirements
- R1: On an accepted `start`, the engine latches `background`. It then writes that value to every address, from 0 to N-1 in ascending order, one write per cycle, and issues no read before all N writes are complete.
- R2: After the fill, target t (starting at 0) is handled as follows. First comes one write of the inverted background to address t. Then come N reads of addresses 0 to N-1 in ascending order, one read per cycle. No cycle carries both a read and a write.
- R3: Read data is taken one cycle after its read request. The expected value is the inverted background when the read address equals the current target, and the background otherwise.
- R4: After a clean scan, the cycle that compares the last read also writes the background value back to the target. The next target (t+1) is then flipped in the following cycle. Targets are visited in ascending order, from 0 to N-1.
- R5: When the last target completes with no mismatch, `done` goes high, `fail` stays low and `busy` goes low. The memory port then stays silent until the next `start`.
- R6: On the first mismatch, `fail` goes high. `fail_target`, `fail_addr` and `fail_bit` hold the target, the read address and the observed read bit. No further memory access is issued, and all of these values are held until the next `start`.
- R7: If the mismatch is found on the compare that shares its cycle with the restore write, that restore write is suppressed.
- R8: After reset, `busy`, `done` and `fail` are low, the failure fields are zero, and no memory access is issued.
- R9: A `start` pulse that arrives while `busy` is high has no effect. The access sequence and the latched background value are unchanged.
- R10: A `start` pulse that arrives after `done` or `fail` clears `fail` and `done` on the accepting edge and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run (ignored while busy) |
| background | input | 1 | Background value: 0 gives all zeros, 1 gives all ones |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | Memory write request |
| mem_wdata | output | 1 | Memory write data |
| mem_re | output | 1 | Memory read request |
| mem_rdata | input | 1 | Memory read data, valid one cycle after `mem_re` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished with no mismatch |
| fail | output | 1 | Mismatch found, results held |
| fail_target | output | ADDR_W | Target address at the time of the mismatch |
| fail_addr | output | ADDR_W | Read address that mismatched |
| fail_bit | output | 1 | Observed bit value at the mismatch |

## Verification
The compare of the last read of a scan falls in the same cycle as the restore write of that target. This is the one place where the compare path and the write path meet. To provoke it, the bench models a read-decoder fault: the highest address reads back the cell just below it. The mismatch therefore appears exactly on the final compare of the target below the highest address. The test is judged by three things: the reported target, read address and bit; an access count that ends on that last read, with no restore write after it; and the faulty cell still holding its flipped value in the memory model.

// File: rtl/wbt_pkg.sv
package wbt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_FLIP,
        ST_SCAN,
        ST_RESTORE,
        ST_DONE,
        ST_FAIL
    } wbt_state_e;

    // expected cell content: the target carries the inverted background
    function automatic logic wbt_expect(input logic is_target, input logic bg);
        return bg ^ is_target;
    endfunction

    function automatic logic wbt_is_rest(input wbt_state_e s);
        return (s == ST_IDLE) || (s == ST_DONE) || (s == ST_FAIL);
    endfunction

endpackage

// File: rtl/wbt_seq.sv
module wbt_seq
    import wbt_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              background,
    input  logic              mismatch,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_wdata,
    output logic              mem_re,
    output logic [ADDR_W-1:0] target,
    output logic              bg_lat,
    output logic              launch,
    output logic              busy,
    output logic              done
);
    localparam logic [ADDR_W-1:0] LAST = '1;

    wbt_state_e        state;
    logic [ADDR_W-1:0] cnt;

    assign launch = start && wbt_is_rest(state);
    assign busy   = !wbt_is_rest(state);
    assign done   = (state == ST_DONE);

    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = cnt;
        mem_wdata = bg_lat;
        unique case (state)
            ST_FILL: mem_we = 1'b1;
            ST_FLIP: begin
                mem_we    = 1'b1;
                mem_addr  = target;
                mem_wdata = ~bg_lat;
            end
            ST_SCAN: mem_re = !mismatch;
            ST_RESTORE: begin
                mem_we   = !mismatch;
                mem_addr = target;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            target <= '0;
            bg_lat <= 1'b0;
        end else begin
            unique case (state)
                ST_FILL: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) state <= ST_FLIP;
                end
                ST_FLIP: begin
                    cnt   <= '0;
                    state <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (mismatch) begin
                        state <= ST_FAIL;
                    end else begin
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST) state <= ST_RESTORE;
                    end
                end
                ST_RESTORE: begin
                    if (mismatch) begin
                        state <= ST_FAIL;
                    end else if (target == LAST) begin
                        state <= ST_DONE;
                    end else begin
                        target <= target + 1'b1;
                        state  <= ST_FLIP;
                    end
                end
                default: begin
                    if (start) begin
                        bg_lat <= background;
                        cnt    <= '0;
                        target <= '0;
                        state  <= ST_FILL;
                    end
                end
            endcase
        end
    end

    AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re)); // R2

    AST_SCAN_AFTER_FLIP: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_re) |-> $past(mem_we) && ($past(mem_wdata) != bg_lat)); // R2

endmodule

// File: rtl/wbt_compare.sv
module wbt_compare
    import wbt_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [ADDR_W-1:0] target,
    input  logic              bg,
    input  logic              rdata,
    output logic              mismatch,
    output logic [ADDR_W-1:0] chk_addr
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } pend_t;

    pend_t pend;

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= '{valid: issue, addr: issue_addr};
    end

    assign chk_addr = pend.addr;
    assign mismatch = pend.valid && (rdata != wbt_expect(pend.addr == target, bg));

endmodule

// File: rtl/wbt_fail_log.sv
module wbt_fail_log #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              capture,
    input  logic [ADDR_W-1:0] cap_target,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic              cap_bit,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_target,
    output logic [ADDR_W-1:0] fail_addr,
    output logic              fail_bit
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail        <= 1'b0;
            fail_target <= '0;
            fail_addr   <= '0;
            fail_bit    <= 1'b0;
        end else if (capture && !fail) begin
            fail        <= 1'b1;
            fail_target <= cap_target;
            fail_addr   <= cap_addr;
            fail_bit    <= cap_bit;
        end
    end

    AST_FAIL_RECORD_HELD: assert property (@(posedge clk) disable iff (rst)
        fail && !clear |=> fail && $stable(fail_addr) && $stable(fail_target) && $stable(fail_bit)); // R6

endmodule

// File: rtl/walkbit_tester.sv
module walkbit_tester #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              background,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_wdata,
    output logic              mem_re,
    input  logic              mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_target,
    output logic [ADDR_W-1:0] fail_addr,
    output logic              fail_bit
);
    logic              mismatch;
    logic              launch;
    logic              bg_lat;
    logic [ADDR_W-1:0] target;
    logic [ADDR_W-1:0] chk_addr;

    wbt_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .background (background),
        .mismatch   (mismatch),
        .mem_addr   (mem_addr),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .mem_re     (mem_re),
        .target     (target),
        .bg_lat     (bg_lat),
        .launch     (launch),
        .busy       (busy),
        .done       (done)
    );

    wbt_compare #(.ADDR_W(ADDR_W)) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .issue      (mem_re),
        .issue_addr (mem_addr),
        .target     (target),
        .bg         (bg_lat),
        .rdata      (mem_rdata),
        .mismatch   (mismatch),
        .chk_addr   (chk_addr)
    );

    wbt_fail_log #(.ADDR_W(ADDR_W)) u_log (
        .clk         (clk),
        .rst         (rst),
        .clear       (launch),
        .capture     (mismatch),
        .cap_target  (target),
        .cap_addr    (chk_addr),
        .cap_bit     (mem_rdata),
        .fail        (fail),
        .fail_target (fail_target),
        .fail_addr   (fail_addr),
        .fail_bit    (fail_bit)
    );

    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        done |-> !fail && !busy); // R5

    AST_SILENT_AFTER_FAIL: assert property (@(posedge clk) disable iff (rst)
        fail |-> !mem_we && !mem_re); // R6

    AST_RESTORE_FOLLOWS_SCAN: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_re) && !mismatch && !fail |-> mem_we && (mem_wdata == bg_lat)); // R4

    AST_NO_WRITE_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
        $rose(fail) |-> !$past(mem_we)); // R7

endmodule

// File: tb/walkbit_tester_bench.sv
module walkbit_tester_bench;
    localparam int AW = 4;
    localparam int N  = 1 << AW;
    localparam int PASS_ACC = N + N * (N + 2);

    // {bg, kind[1:0], fa[3:0], fb[3:0], sv, exp_fail, exp_t[3:0], exp_a[3:0], exp_b}
    // kind 0 none, 1 stuck cell fa at sv, 2 write to fa also writes fb, 3 read of fa returns fb
    localparam int NV = 8;
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 4'd0,  4'd0,  1'b0},
        {1'b1, 2'd0, 4'd0,  4'd0,  1'b0, 1'b0, 4'd0,  4'd0,  1'b0},
        {1'b0, 2'd1, 4'd5,  4'd0,  1'b1, 1'b1, 4'd0,  4'd5,  1'b1},
        {1'b0, 2'd1, 4'd5,  4'd0,  1'b0, 1'b1, 4'd5,  4'd5,  1'b0},
        {1'b1, 2'd1, 4'd0,  4'd0,  1'b1, 1'b1, 4'd0,  4'd0,  1'b1},
        {1'b0, 2'd2, 4'd3,  4'd9,  1'b0, 1'b1, 4'd3,  4'd9,  1'b1},
        {1'b1, 2'd2, 4'd15, 4'd0,  1'b0, 1'b1, 4'd15, 4'd0,  1'b0},
        {1'b0, 2'd3, 4'd15, 4'd14, 1'b0, 1'b1, 4'd14, 4'd15, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          background = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_we, mem_wdata, mem_re, mem_rdata;
    logic          busy, done, fail, fail_bit;
    logic [AW-1:0] fail_target, fail_addr;

    int errors = 0;
    int checks = 0;

    logic [1:0]    f_kind = 2'd0;
    logic [AW-1:0] f_a = '0, f_b = '0;
    logic          f_sv = 1'b0;
    logic          mem [N];

    int   acc_n = 0;
    int   order_err = 0;
    logic exp_bg = 1'b0;

    always #10 clk = ~clk;

    walkbit_tester #(.ADDR_W(AW)) u_walkbit_tester (
        .clk(clk), .rst(rst), .start(start), .background(background),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .fail(fail), .fail_target(fail_target), .fail_addr(fail_addr),
        .fail_bit(fail_bit)
    );

    // faulty single-bit memory with one-cycle read latency
    always_ff @(posedge clk) begin
        if (mem_we) begin
            if (!(f_kind == 2'd1 && mem_addr == f_a)) mem[mem_addr] <= mem_wdata;
            if (f_kind == 2'd2 && mem_addr == f_a) mem[f_b] <= mem_wdata;
        end
        if (mem_re) begin
            if (f_kind == 2'd3 && mem_addr == f_a)    mem_rdata <= mem[f_b];
            else if (f_kind == 2'd1 && mem_addr == f_a) mem_rdata <= f_sv;
            else                                       mem_rdata <= mem[mem_addr];
        end
    end

    // expected access stream from R1, R2, R4
    always @(negedge clk) begin
        if (mem_we || mem_re) begin
            automatic int  m = acc_n - N;
            automatic int  t = (acc_n < N) ? 0 : m / (N + 2);
            automatic int  r = (acc_n < N) ? 0 : m % (N + 2);
            automatic bit  ew;
            automatic int  ea;
            automatic logic ed;
            if (acc_n < N)        begin ew = 1; ea = acc_n; ed = exp_bg;  end
            else if (r == 0)      begin ew = 1; ea = t;     ed = ~exp_bg; end
            else if (r == N + 1)  begin ew = 1; ea = t;     ed = exp_bg;  end
            else                  begin ew = 0; ea = r - 1; ed = 1'b0;    end
            if (mem_we != ew || mem_re == ew || int'(mem_addr) != ea ||
                (ew && mem_wdata != ed))
                order_err = order_err + 1;
            acc_n = acc_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic launch_run(input logic bg);
        @(negedge clk);
        acc_n = 0;
        order_err = 0;
        exp_bg = bg;
        background = bg;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(output bit timed_out);
        timed_out = 1;
        for (int i = 0; i < 2000; i++) begin
            if (done || fail) begin
                timed_out = 0;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit to;
        int acc_hold;
        for (int i = 0; i < N; i++) mem[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R8 reset state
        chk(!busy && !done && !fail, "R8 flags after reset", {busy, done, fail}, 0);
        chk(!mem_we && !mem_re, "R8 no access after reset", {mem_we, mem_re}, 0);
        chk(fail_target == 0 && fail_addr == 0 && !fail_bit, "R8 fields zero",
            int'(fail_addr), 0);

        // table of fault scenarios
        for (int v = 0; v < NV; v++) begin
            logic bg, sv, ef, eb;
            logic [1:0] kind;
            logic [AW-1:0] fa, fb, et, ea;
            {bg, kind, fa, fb, sv, ef, et, ea, eb} = VEC[v];
            f_kind = kind; f_a = fa; f_b = fb; f_sv = sv;
            launch_run(bg);
            // R10: accepting edge clears prior outcome
            chk(busy && !fail && !done, "R10 restart clears flags", {busy, fail, done}, 4);
            wait_end(to);
            chk(!to, "R5 R6 run ends", v, 0);
            chk(fail == ef, "R5 R6 outcome", fail, ef);
            chk(order_err == 0, "R1 R2 R4 access order", order_err, 0);
            if (ef) begin
                chk(fail_target == et, "R6 fail_target", fail_target, et);
                chk(fail_addr == ea, "R6 fail_addr", fail_addr, ea);
                chk(fail_bit == eb, "R6 fail_bit", fail_bit, eb);
                acc_hold = acc_n;
                repeat (20) @(negedge clk);
                chk(acc_n == acc_hold && fail && fail_addr == ea, "R6 stopped and held",
                    acc_n, acc_hold);
                if (v == 4)  // R3 fault seen on the very first compare of the scan
                    chk(acc_hold == N + 2, "R3 first compare latency", acc_hold, N + 2);
                if (v == 7) begin
                    // R7 last compare coincides with restore; restore suppressed
                    chk(acc_hold == N + 14 * (N + 2) + N + 1, "R7 access count",
                        acc_hold, N + 14 * (N + 2) + N + 1);
                    chk(mem[14] == 1'b1, "R7 target not restored", mem[14], 1);
                end
            end else begin
                chk(done && !busy && acc_n == PASS_ACC, "R5 clean completion",
                    acc_n, PASS_ACC);
                repeat (10) @(negedge clk);
                chk(acc_n == PASS_ACC && done, "R5 port silent after done", acc_n, PASS_ACC);
            end
        end

        // R9: start while busy is ignored
        f_kind = 2'd0;
        launch_run(1'b1);
        repeat (40) @(negedge clk);
        background = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end(to);
        chk(!to && done && !fail, "R9 run unaffected", fail, 0);
        chk(acc_n == PASS_ACC && order_err == 0, "R9 sequence unchanged", order_err, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule